// File: doc/BRIEF.md
# NOR Flash Program/Erase Sequencer

This block sits on the host side of a byte-wide parallel NOR flash and turns a single request into the full bus activity needed to program one byte, erase one sector or erase the whole chip. A request carries an operation code, a target address and a data byte. It is taken over a valid/ready handshake, and only while the sequencer is idle. The sequencer then drives the protected command-write sequence onto the flash bus. Every write is framed by a setup phase, a strobe phase with chip enable and write enable low together, and a hold phase. Output enable stays high for the whole write.

Once the last write of the sequence has finished, the sequencer reads the device over and over. While the device is busy with its internal operation, bit 6 of the data bus flips on every read. The operation counts as finished as soon as two reads in a row return the same bit 6. A poll budget limits the wait. The result is reported with a one-cycle done pulse and a one-bit status. All bus timing is given in system-clock cycles through parameters.

Top module: `nor_flash_seq`

## Requirements
- R1: `req_ready` is high only while idle, including straight after reset. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` drops on the next cycle. A `req_valid` raised while busy starts nothing: the bus carries only the writes of the current operation, and no writes appear after its done pulse.
- R2: Operation code 0 (program) produces exactly four writes, in this order, as (address, data): (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), (target address, data byte).
- R3: Operation code 1 (sector erase) produces exactly six writes, in this order: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), (target address, 0x30).
- R4: Operation codes 2 and 3 (chip erase) produce the same first five writes as R3, followed by (0x5555, 0x10) as the sixth write.
- R5: During every write strobe, `fl_ce_n` and `fl_we_n` are low together, `fl_oe_n` is high and the data bus is driven. The low phase of `fl_we_n` lasts `WE_LOW_CYC` cycles, or `GLITCH_CYC+1` cycles when `WE_LOW_CYC` is not greater than `GLITCH_CYC`.
- R6: No status read starts before the rising edge of `fl_we_n` that ends the final write. Each read holds `fl_ce_n` and `fl_oe_n` low, with the data bus released, for exactly `READ_CYC` cycles. Consecutive reads are separated by at least `GAP_CYC` cycles with `fl_oe_n` high.
- R7: The operation completes with status 0 at the first read whose bit 6 equals bit 6 of the read before it. The other seven data bits have no effect on this decision.
- R8: If no such match occurs within `MAX_POLLS` reads, the operation ends after exactly `MAX_POLLS` reads with status 1. A match on read number `MAX_POLLS` itself reports status 0.
- R9: `done` is a single-cycle pulse carrying `done_status`. Whenever the sequencer is idle, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high and `fl_dq_oe` is low, including after a timeout.
- R10: After reset, `done` is low, all strobes are high, `fl_dq_oe` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_op | input | 2 | 0 program, 1 sector erase, 2 or 3 chip erase |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 1 | 0 completed, 1 poll budget exhausted |
| fl_addr | output | AW | Flash address bus |
| fl_dq_o | output | 8 | Flash data out |
| fl_dq_oe | output | 1 | Flash data bus drive enable |
| fl_dq_i | input | 8 | Flash data in |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The bench models the flash. It takes a write on each rising edge of the write strobe, and after the final command write it keeps bit 6 flipping for a chosen number of reads while the other data bits change on every read. One run completes exactly on the last allowed read and another needs one read more; a design with an off-by-one in the poll budget gets one of these two results wrong. Because the low data bits always change, a design that compared the whole byte would never complete and would time out. A request raised mid-operation is offered to catch a sequencer that queues or restarts. The strobe and ready checks on every clock catch output enable falling during a write, a strobe shorter than the glitch limit, and a read issued before the final write has ended.

// File: rtl/nfseq_pkg.sv
package nfseq_pkg;

  localparam logic [1:0] OP_PROG = 2'd0;
  localparam logic [1:0] OP_SECT = 2'd1;

  localparam logic [15:0] UNLOCK_A0 = 16'h5555;
  localparam logic [15:0] UNLOCK_A1 = 16'h2AAA;
  localparam logic [7:0]  UNLOCK_D0 = 8'hAA;
  localparam logic [7:0]  UNLOCK_D1 = 8'h55;
  localparam logic [7:0]  CODE_PROG = 8'hA0;
  localparam logic [7:0]  CODE_ERASE = 8'h80;
  localparam logic [7:0]  CODE_CHIP = 8'h10;
  localparam logic [7:0]  CODE_SECT = 8'h30;

  localparam int TOGGLE_BIT = 6;

  typedef enum logic [2:0] {
    B_IDLE, B_SETUP, B_STROBE, B_HOLD, B_RDACT, B_GAP
  } bus_st_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WWAIT, S_RISSUE, S_RWAIT
  } seq_st_e;

endpackage

// File: rtl/nfseq_cmd_sel.sv
module nfseq_cmd_sel #(
  parameter int AW = 17
) (
  input  logic [1:0]    op,
  input  logic [2:0]    idx,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    tgt_data,
  output logic [AW-1:0] cmd_addr,
  output logic [7:0]    cmd_data,
  output logic          cmd_last
);
  import nfseq_pkg::*;

  localparam logic [AW-1:0] A0 = AW'(UNLOCK_A0);
  localparam logic [AW-1:0] A1 = AW'(UNLOCK_A1);

  always_comb begin
    cmd_addr = A0;
    cmd_data = UNLOCK_D0;
    if (op == OP_PROG) begin
      cmd_last = (idx == 3'd3);
      case (idx)
        3'd0: begin cmd_addr = A0; cmd_data = UNLOCK_D0; end
        3'd1: begin cmd_addr = A1; cmd_data = UNLOCK_D1; end
        3'd2: begin cmd_addr = A0; cmd_data = CODE_PROG; end
        default: begin cmd_addr = tgt_addr; cmd_data = tgt_data; end
      endcase
    end else begin
      cmd_last = (idx == 3'd5);
      case (idx)
        3'd0, 3'd3: begin cmd_addr = A0; cmd_data = UNLOCK_D0; end
        3'd1, 3'd4: begin cmd_addr = A1; cmd_data = UNLOCK_D1; end
        3'd2:       begin cmd_addr = A0; cmd_data = CODE_ERASE; end
        default: begin
          if (op == OP_SECT) begin
            cmd_addr = tgt_addr;
            cmd_data = CODE_SECT;
          end else begin
            cmd_addr = A0;
            cmd_data = CODE_CHIP;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/nfseq_bus_cycle.sv
module nfseq_bus_cycle #(
  parameter int AW        = 17,
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 2,
  parameter int HOLD_CYC  = 1,
  parameter int READ_CYC  = 2,
  parameter int GAP_CYC   = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          is_read,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          fin,
  output logic          rbit,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  input  logic [7:0]    fl_dq_i
);
  import nfseq_pkg::*;

  localparam int M0   = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
  localparam int M1   = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
  localparam int M2   = (M0 > M1) ? M0 : M1;
  localparam int MAXC = (M2 > GAP_CYC) ? M2 : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  bus_st_e       st;
  logic [CW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);

  logic rd_unused;
  assign rd_unused = ^{fl_dq_i[7], fl_dq_i[5:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= B_IDLE;
      cnt      <= '0;
      fin      <= 1'b0;
      rbit     <= 1'b0;
      fl_addr  <= '0;
      fl_dq_o  <= '0;
      fl_dq_oe <= 1'b0;
      fl_ce_n  <= 1'b1;
      fl_we_n  <= 1'b1;
      fl_oe_n  <= 1'b1;
    end else begin
      fin <= 1'b0;
      case (st)
        B_IDLE: begin
          if (start) begin
            fl_addr <= addr;
            if (is_read) begin
              fl_ce_n <= 1'b0;
              fl_oe_n <= 1'b0;
              cnt     <= CW'(READ_CYC - 1);
              st      <= B_RDACT;
            end else begin
              fl_dq_o  <= wdata;
              fl_dq_oe <= 1'b1;
              cnt      <= CW'(SETUP_CYC - 1);
              st       <= B_SETUP;
            end
          end
        end
        B_SETUP: begin
          if (cnt_zero) begin
            fl_ce_n <= 1'b0;
            fl_we_n <= 1'b0;
            cnt     <= CW'(WE_CYC - 1);
            st      <= B_STROBE;
          end else cnt <= cnt - 1'b1;
        end
        B_STROBE: begin
          if (cnt_zero) begin
            fl_ce_n <= 1'b1;
            fl_we_n <= 1'b1;
            cnt     <= CW'(HOLD_CYC - 1);
            st      <= B_HOLD;
          end else cnt <= cnt - 1'b1;
        end
        B_HOLD: begin
          if (cnt_zero) begin
            fl_dq_oe <= 1'b0;
            fin      <= 1'b1;
            st       <= B_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        B_RDACT: begin
          if (cnt_zero) begin
            rbit    <= fl_dq_i[TOGGLE_BIT];
            fl_ce_n <= 1'b1;
            fl_oe_n <= 1'b1;
            cnt     <= CW'(GAP_CYC - 1);
            st      <= B_GAP;
          end else cnt <= cnt - 1'b1;
        end
        B_GAP: begin
          if (cnt_zero) begin
            fin <= 1'b1;
            st  <= B_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= B_IDLE;
      endcase
    end
  end

  // checker counters for strobe widths
  logic [CW:0] we_lo_cnt;
  logic [CW:0] oe_lo_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo_cnt <= '0;
      oe_lo_cnt <= '0;
    end else begin
      we_lo_cnt <= fl_we_n ? '0 : we_lo_cnt + 1'b1;
      oe_lo_cnt <= fl_oe_n ? '0 : oe_lo_cnt + 1'b1;
    end
  end

  p_strobe_phase_r5: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_dq_oe));
  p_we_width_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (we_lo_cnt == (CW+1)'(WE_CYC)));
  p_read_phase_r6: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> (!fl_ce_n && fl_we_n && !fl_dq_oe));
  p_oe_width_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_oe_n) |-> (oe_lo_cnt == (CW+1)'(READ_CYC)));

endmodule

// File: rtl/nor_flash_seq.sv
module nor_flash_seq #(
  parameter int AW         = 17,
  parameter int SETUP_CYC  = 1,
  parameter int WE_LOW_CYC = 2,
  parameter int GLITCH_CYC = 1,
  parameter int HOLD_CYC   = 1,
  parameter int READ_CYC   = 2,
  parameter int GAP_CYC    = 2,
  parameter int MAX_POLLS  = 100000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          done,
  output logic          done_status,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  import nfseq_pkg::*;

  localparam int WE_CYC = (WE_LOW_CYC > GLITCH_CYC) ? WE_LOW_CYC : GLITCH_CYC + 1;
  localparam int PW     = $clog2(MAX_POLLS + 1);

  seq_st_e       st;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [2:0]    idx;
  logic [PW-1:0] poll_cnt;
  logic          prev_bit;
  logic          have_prev;

  logic          eng_start;
  logic          eng_read;
  logic          eng_fin;
  logic          eng_bit;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic          cmd_last;

  assign eng_start = (st == S_ISSUE) || (st == S_RISSUE);
  assign eng_read  = (st == S_RISSUE);

  nfseq_cmd_sel #(.AW(AW)) cmd_i (
    .op       (op_q),
    .idx      (idx),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .cmd_last (cmd_last)
  );

  nfseq_bus_cycle #(
    .AW        (AW),
    .SETUP_CYC (SETUP_CYC),
    .WE_CYC    (WE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .READ_CYC  (READ_CYC),
    .GAP_CYC   (GAP_CYC)
  ) bus_i (
    .clk      (clk),
    .rst      (rst),
    .start    (eng_start),
    .is_read  (eng_read),
    .addr     (eng_read ? addr_q : cmd_addr),
    .wdata    (cmd_data),
    .fin      (eng_fin),
    .rbit     (eng_bit),
    .fl_addr  (fl_addr),
    .fl_dq_o  (fl_dq_o),
    .fl_dq_oe (fl_dq_oe),
    .fl_ce_n  (fl_ce_n),
    .fl_we_n  (fl_we_n),
    .fl_oe_n  (fl_oe_n),
    .fl_dq_i  (fl_dq_i)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      req_ready   <= 1'b1;
      done        <= 1'b0;
      done_status <= 1'b0;
      op_q        <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      idx         <= '0;
      poll_cnt    <= '0;
      prev_bit    <= 1'b0;
      have_prev   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            op_q      <= req_op;
            addr_q    <= req_addr;
            data_q    <= req_data;
            idx       <= '0;
            req_ready <= 1'b0;
            st        <= S_ISSUE;
          end
        end
        S_ISSUE: st <= S_WWAIT;
        S_WWAIT: begin
          if (eng_fin) begin
            if (cmd_last) begin
              poll_cnt  <= '0;
              have_prev <= 1'b0;
              st        <= S_RISSUE;
            end else begin
              idx <= idx + 1'b1;
              st  <= S_ISSUE;
            end
          end
        end
        S_RISSUE: st <= S_RWAIT;
        S_RWAIT: begin
          if (eng_fin) begin
            poll_cnt  <= poll_cnt + 1'b1;
            prev_bit  <= eng_bit;
            have_prev <= 1'b1;
            if (have_prev && (prev_bit == eng_bit)) begin
              done        <= 1'b1;
              done_status <= 1'b0;
              req_ready   <= 1'b1;
              st          <= S_IDLE;
            end else if (poll_cnt == PW'(MAX_POLLS - 1)) begin
              done        <= 1'b1;
              done_status <= 1'b1;
              req_ready   <= 1'b1;
              st          <= S_IDLE;
            end else begin
              st <= S_RISSUE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe));
  p_read_after_writes_r6: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> (st == S_RWAIT));
  p_poll_bound_r8: assert property (@(posedge clk) disable iff (rst)
    poll_cnt <= PW'(MAX_POLLS));
  p_timeout_count_r8: assert property (@(posedge clk) disable iff (rst)
    (done && done_status) |-> (poll_cnt == PW'(MAX_POLLS)));
  p_match_needs_two_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !done_status) |-> (poll_cnt >= PW'(2)));

endmodule

// File: tb/nor_flash_seq_tb_top.sv
module nor_flash_seq_tb_top;

  localparam int AW      = 17;
  localparam int WE_LOW  = 2;
  localparam int GLITCH  = 3;
  localparam int EXP_WE  = 4;
  localparam int READ_C  = 2;
  localparam int GAP_C   = 2;
  localparam int MAXP    = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          done, done_status;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dq_o;
  logic          fl_dq_oe;
  logic [7:0]    fl_dq_i;
  logic          fl_ce_n, fl_we_n, fl_oe_n;

  always #2 clk = ~clk;

  nor_flash_seq #(
    .AW(AW), .SETUP_CYC(1), .WE_LOW_CYC(WE_LOW), .GLITCH_CYC(GLITCH),
    .HOLD_CYC(1), .READ_CYC(READ_C), .GAP_CYC(GAP_C), .MAX_POLLS(MAXP)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .done(done), .done_status(done_status), .fl_addr(fl_addr),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // flash model state
  logic [AW-1:0] wa_q[$];
  logic [7:0]    wd_q[$];
  int  exp_len   = 4;
  int  busy_left = 0;
  int  cur_k     = 0;
  bit  armed     = 1'b0;
  bit  tog       = 1'b0;
  int  reads     = 0;
  int  early     = 0;
  int  we_low    = 0;
  int  oe_low    = 0;
  int  oe_high   = 0;
  bit  prev_we   = 1'b1;
  bit  prev_oe   = 1'b1;
  bit  mon_on    = 1'b0;
  bit  busy      = 1'b0;
  logic [7:0] junk;

  assign junk    = 8'(reads * 37 + 5);
  assign fl_dq_i = {junk[7], tog, junk[5:0]};

  always @(negedge clk) begin
    if (mon_on) begin
      // ready / busy reference (R1, R9)
      if (done) begin
        chk(busy, "R9", "done while idle", 0, 1);
        busy = 1'b0;
      end
      chk(req_ready == !busy, "R1", "req_ready", req_ready, !busy);
      if (!busy)
        chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R9", "idle bus",
            {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
      if (req_valid && req_ready) busy = 1'b1;

      // write strobe (R5)
      if (!fl_we_n) begin
        chk(!fl_ce_n && fl_oe_n && fl_dq_oe, "R5", "strobe phase",
            {fl_ce_n, fl_oe_n, fl_dq_oe}, 3'b011);
        we_low++;
      end else if (!prev_we) begin
        chk(we_low == EXP_WE, "R5", "we low width", we_low, EXP_WE);
        we_low = 0;
        wa_q.push_back(fl_addr);
        wd_q.push_back(fl_dq_o);
        if (wa_q.size() == exp_len) begin
          armed     = 1'b1;
          busy_left = cur_k;
        end
      end

      // status reads (R6)
      if (!fl_oe_n) begin
        if (prev_oe) begin
          if (!armed) early++;
          if (reads > 0) chk(oe_high >= GAP_C, "R6", "read gap", oe_high, GAP_C);
        end
        chk(!fl_ce_n && fl_we_n && !fl_dq_oe, "R6", "read phase",
            {fl_ce_n, fl_we_n, fl_dq_oe}, 3'b010);
        oe_low++;
      end else begin
        if (!prev_oe) begin
          chk(oe_low == READ_C, "R6", "oe low width", oe_low, READ_C);
          reads++;
          if (busy_left > 0) begin
            tog = ~tog;
            busy_left--;
          end
          oe_low  = 0;
          oe_high = 0;
        end
        oe_high++;
      end
      prev_we = fl_we_n;
      prev_oe = fl_oe_n;
    end
  end

  int cyc = 0;
  bit wd_hit = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      chk(1'b0, "R9", "watchdog", cyc, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [7:0] d, input int k, input bit inject);
    logic [AW-1:0] ea[6];
    logic [7:0]    ed[6];
    string tag;
    int exp_reads;
    bit exp_st;
    int guard;
    wa_q.delete();
    wd_q.delete();
    exp_len = (op == 2'd0) ? 4 : 6;
    cur_k   = k;
    armed   = 1'b0;
    reads   = 0;
    early   = 0;
    tag = (op == 2'd0) ? "R2" : (op == 2'd1) ? "R3" : "R4";
    ea[0] = 17'h05555; ed[0] = 8'hAA;
    ea[1] = 17'h02AAA; ed[1] = 8'h55;
    if (op == 2'd0) begin
      ea[2] = 17'h05555; ed[2] = 8'hA0;
      ea[3] = a;         ed[3] = d;
    end else begin
      ea[2] = 17'h05555; ed[2] = 8'h80;
      ea[3] = 17'h05555; ed[3] = 8'hAA;
      ea[4] = 17'h02AAA; ed[4] = 8'h55;
      if (op == 2'd1) begin ea[5] = a; ed[5] = 8'h30; end
      else begin ea[5] = 17'h05555; ed[5] = 8'h10; end
    end
    exp_reads = (k + 2 > MAXP) ? MAXP : k + 2;
    exp_st    = (k + 2 > MAXP);

    @(posedge clk); #1;
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    req_op = ~op; req_addr = ~a; req_data = ~d;
    if (inject) begin
      repeat (10) @(posedge clk);
      #1 req_valid = 1'b1;
      repeat (3) @(posedge clk);
      #1 req_valid = 1'b0;
    end
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!done && guard < 5000);
    chk(done, "R9", "done seen", done, 1);
    chk(done_status == exp_st, exp_st ? "R8" : "R7", "status", done_status, exp_st);
    chk(reads == exp_reads, exp_st ? "R8" : "R7", "read count", reads, exp_reads);
    chk(early == 0, "R6", "reads before last write", early, 0);
    chk(wa_q.size() == exp_len, tag, "write count", wa_q.size(), exp_len);
    for (int i = 0; i < exp_len && i < wa_q.size(); i++) begin
      chk(wa_q[i] == ea[i], tag, "write addr", wa_q[i], ea[i]);
      chk(wd_q[i] == ed[i], tag, "write data", wd_q[i], ed[i]);
    end
    if (inject) begin
      repeat (20) @(negedge clk);
      chk(wa_q.size() == exp_len, "R1", "no writes after ignored request",
          wa_q.size(), exp_len);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
    chk(done == 1'b0, "R10", "done after reset", done, 0);
    chk({fl_ce_n, fl_we_n, fl_oe_n} == 3'b111, "R10", "strobes after reset",
        {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    chk(fl_dq_oe == 1'b0, "R10", "bus released after reset", fl_dq_oe, 0);
    mon_on = 1'b1;

    tog = 1'b0; run_op(2'd0, 17'h12345, 8'h3C, 3, 1'b0);   // R2, R7
    tog = 1'b1; run_op(2'd1, 17'h0F000, 8'h00, 0, 1'b0);   // R3, fastest completion
    tog = 1'b0; run_op(2'd2, 17'h1FFFF, 8'h00, 5, 1'b0);   // R4
    tog = 1'b1; run_op(2'd0, 17'h00001, 8'hFF, 6, 1'b0);   // R8 match on last read
    tog = 1'b0; run_op(2'd1, 17'h1A000, 8'h00, 7, 1'b0);   // R8 one read short
    tog = 1'b1; run_op(2'd3, 17'h00000, 8'h00, 50, 1'b0);  // R4 alt code, R8 timeout
    tog = 1'b0; run_op(2'd0, 17'h0BEEF, 8'h5A, 2, 1'b1);   // R1 ignored request
    tog = 1'b1; run_op(2'd0, 17'h0CAFE, 8'hA5, 1, 1'b0);   // R2 back to back

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule